// File: doc/BRIEF.md
# Page Load Buffer with Timed Commit

This block gathers bytes into a page buffer and later stores the whole page into a backing memory with a single commit command. Two independent stores are provided. The program store is word-organised: each in-page slot holds a 16-bit word, and its low byte must be loaded before its high byte. The data store is byte-organised: each slot carries a "loaded" mark, so a commit only changes the marked locations. The data store also accepts a direct single-byte write that erases the location and then programs it.

Commands arrive on a valid/ready stream. A command carries a 4-bit operation code, a 13-bit address and one data byte. The address splits into an in-page offset (bits [5:0]) and a page number (bits [12:6]). Reads return one byte on a valid/ready response stream. The command stream stalls only while a read response is held by the consumer: `cmd_ready` is low exactly when `rsp_valid` is high and `rsp_ready` is low, and a held response keeps its data stable. A commit or a byte write starts a write interval of `wr_time` cycles, shown on `busy`. Commands that change state are dropped during that interval and raise the sticky `err` flag. Reads are still served during the interval.

Memory is modelled as a register array of `MEM_PAGES` pages per store. Erase sets a byte to 0xFF. Programming is a bitwise AND of the old contents with the new data.

Top module: `page_commit_buffer`

## Requirements
- R1: A command is taken on a cycle where cmd_valid and cmd_ready are both high. cmd_ready is low exactly while rsp_valid is high and rsp_ready is low. While a response waits, rsp_valid stays high and rsp_data does not change.
- R2: Three read codes return one byte. Code 6 reads the low byte of a program word, code 7 its high byte, and code 8 a data-store byte. rsp_valid is high in the cycle after the read is taken. Both stores reset to all 0xFF. A read of a page number at or above MEM_PAGES returns 0x00.
- R3: Code 0 (load low) puts the data byte into the low half of the program-buffer word at offset addr[5:0] and marks that offset's low byte as loaded.
- R4: Code 1 (load high) writes the high half of the buffer word at addr[5:0] only if that offset's low byte was loaded since the last program commit. Otherwise the command is ignored and err is set.
- R5: Code 2 (program commit) takes the page number from addr[12:6]. Every word of that page becomes its old value AND the buffer word. The buffer then returns to 0xFFFF and all low-byte marks clear.
- R6: Code 3 (load byte) stores the data byte in the data buffer at addr[5:0] and marks it. Code 4 (data commit) writes only the marked slots into page addr[12:6], leaves every other location unchanged, and clears all marks.
- R7: Code 5 (byte write) erases the data-store byte at addr[12:0] and then programs it, so the location ends up equal to the data byte whatever it held before.
- R8: A commit or byte write that is carried out raises busy in the next cycle. busy stays high for exactly wr_time cycles; a wr_time of 0 gives no busy interval.
- R9: While busy is high, codes 0 to 5 are ignored, leave both stores and buffers unchanged, and set err. Reads are served normally.
- R10: A commit or byte write to a page at or above MEM_PAGES is ignored, sets err and does not start busy. Codes 9 to 15 are ignored and set err.
- R11: After reset, busy, err and rsp_valid are 0 and cmd_ready is 1. Once set, err stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 4 | Operation code |
| cmd_addr | input | 13 | Page number [12:6], in-page offset [5:0] |
| cmd_data | input | 8 | Data byte for loads and writes |
| wr_time | input | 16 | Length of the write interval in cycles |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 8 | Read response byte |
| busy | output | 1 | Write interval in progress |
| err | output | 1 | Sticky flag for a dropped command |

## Verification
A bad write-interval counter shows on `busy` in the cycle after a commit, so the bench checks the exact cycle where busy rises and falls. A stale loaded mark or ordering flag has no direct output. It only shows after a later commit and a read-back, or as an unexpected `err` on a high-byte load. For that reason each scenario commits and reads back its page, and it repeats commits to expose leftover marks and the AND programming model. A response register that loses or changes data under back-pressure shows on `rsp_data` and `cmd_ready` in the stalled cycles themselves.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
  typedef enum logic [3:0] {
    OP_LOAD_LO     = 4'd0,
    OP_LOAD_HI     = 4'd1,
    OP_COMMIT_PROG = 4'd2,
    OP_LOAD_BYTE   = 4'd3,
    OP_COMMIT_DATA = 4'd4,
    OP_WRITE_BYTE  = 4'd5,
    OP_READ_LO     = 4'd6,
    OP_READ_HI     = 4'd7,
    OP_READ_DATA   = 4'd8
  } op_e;

  localparam logic [7:0]  ERASED_BYTE = 8'hFF;
  localparam logic [15:0] ERASED_WORD = 16'hFFFF;
endpackage

// File: rtl/pcb_busy_timer.sv
module pcb_busy_timer #(
  parameter int TIME_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [TIME_W-1:0] wr_time,
  output logic              busy
);
  logic [TIME_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (start)          cnt_q <= wr_time;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/pcb_word_store.sv
module pcb_word_store
  import pcb_pkg::*;
#(
  parameter int OFS_W  = 6,
  parameter int PIDX_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic              commit,
  input  logic [PIDX_W-1:0] page,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [7:0]        din,
  input  logic              rd_hi,
  output logic              lo_seen,
  output logic [7:0]        rd_data
);
  localparam int SLOTS = 1 << OFS_W;
  localparam int DEPTH = 1 << (PIDX_W + OFS_W);

  logic [15:0]      pbuf_q [SLOTS];
  logic [SLOTS-1:0] lo_q;
  logic [15:0]      mem_q  [DEPTH];
  logic [15:0]      word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) pbuf_q[i] <= ERASED_WORD;
      for (int j = 0; j < DEPTH; j++) mem_q[j] <= ERASED_WORD;
      lo_q <= '0;
    end else if (commit) begin
      // program-only page write: bits can only fall from 1 to 0
      for (int i = 0; i < SLOTS; i++) begin
        mem_q[{page, OFS_W'(i)}] <= mem_q[{page, OFS_W'(i)}] & pbuf_q[i];
        pbuf_q[i] <= ERASED_WORD;
      end
      lo_q <= '0;
    end else if (ld_lo) begin
      pbuf_q[ofs][7:0] <= din;
      lo_q[ofs]        <= 1'b1;
    end else if (ld_hi) begin
      pbuf_q[ofs][15:8] <= din;
    end
  end

  assign lo_seen = lo_q[ofs];
  assign word    = mem_q[{page, ofs}];
  assign rd_data = rd_hi ? word[15:8] : word[7:0];
endmodule

// File: rtl/pcb_byte_store.sv
module pcb_byte_store
  import pcb_pkg::*;
#(
  parameter int OFS_W  = 6,
  parameter int PIDX_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic              commit,
  input  logic              wr_byte,
  input  logic [PIDX_W-1:0] page,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [7:0]        din,
  output logic [7:0]        rd_data
);
  localparam int SLOTS = 1 << OFS_W;
  localparam int DEPTH = 1 << (PIDX_W + OFS_W);

  logic [7:0]       bbuf_q [SLOTS];
  logic [SLOTS-1:0] mark_q;
  logic [7:0]       mem_q  [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) bbuf_q[i] <= ERASED_BYTE;
      for (int j = 0; j < DEPTH; j++) mem_q[j] <= ERASED_BYTE;
      mark_q <= '0;
    end else if (commit) begin
      // erase then program, only where a byte was loaded
      for (int i = 0; i < SLOTS; i++) begin
        if (mark_q[i]) mem_q[{page, OFS_W'(i)}] <= ERASED_BYTE & bbuf_q[i];
      end
      mark_q <= '0;
    end else if (wr_byte) begin
      mem_q[{page, ofs}] <= ERASED_BYTE & din;
    end else if (ld) begin
      bbuf_q[ofs] <= din;
      mark_q[ofs] <= 1'b1;
    end
  end

  assign rd_data = mem_q[{page, ofs}];
endmodule

// File: rtl/page_commit_buffer.sv
module page_commit_buffer
  import pcb_pkg::*;
#(
  parameter int OFS_W     = 6,
  parameter int PG_W      = 7,
  parameter int MEM_PAGES = 4,
  parameter int TIME_W    = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  output logic                  cmd_ready,
  input  logic [3:0]            cmd_op,
  input  logic [OFS_W+PG_W-1:0] cmd_addr,
  input  logic [7:0]            cmd_data,
  input  logic [TIME_W-1:0]     wr_time,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [7:0]            rsp_data,
  output logic                  busy,
  output logic                  err
);
  localparam int ADDR_W = OFS_W + PG_W;
  localparam int PIDX_W = (MEM_PAGES > 1) ? $clog2(MEM_PAGES) : 1;
  localparam logic [PG_W-1:0] PG_LIMIT = PG_W'(MEM_PAGES);

  logic              fire, pg_ok, lo_seen;
  logic [OFS_W-1:0]  ofs;
  logic [PG_W-1:0]   pg;
  logic [PIDX_W-1:0] pidx;
  logic              is_read, is_mut, bad_op, pg_op;
  logic              do_lo, do_hi, do_cp, do_lb, do_cd, do_wb, start, err_set;
  logic [7:0]        word_rd, byte_rd, rd_sel;
  logic              rsp_valid_q, err_q;
  logic [7:0]        rsp_data_q;

  assign cmd_ready = !rsp_valid_q || rsp_ready;
  assign fire      = cmd_valid && cmd_ready;
  assign ofs       = cmd_addr[OFS_W-1:0];
  assign pg        = cmd_addr[ADDR_W-1:OFS_W];
  assign pidx      = pg[PIDX_W-1:0];
  assign pg_ok     = (pg < PG_LIMIT);

  assign is_read = (cmd_op == OP_READ_LO) || (cmd_op == OP_READ_HI) ||
                   (cmd_op == OP_READ_DATA);
  assign is_mut  = (cmd_op <= OP_WRITE_BYTE);
  assign bad_op  = !is_read && !is_mut;
  assign pg_op   = (cmd_op == OP_COMMIT_PROG) || (cmd_op == OP_COMMIT_DATA) ||
                   (cmd_op == OP_WRITE_BYTE);

  assign do_lo = fire && !busy && (cmd_op == OP_LOAD_LO);
  assign do_hi = fire && !busy && (cmd_op == OP_LOAD_HI) && lo_seen;
  assign do_cp = fire && !busy && (cmd_op == OP_COMMIT_PROG) && pg_ok;
  assign do_lb = fire && !busy && (cmd_op == OP_LOAD_BYTE);
  assign do_cd = fire && !busy && (cmd_op == OP_COMMIT_DATA) && pg_ok;
  assign do_wb = fire && !busy && (cmd_op == OP_WRITE_BYTE) && pg_ok;
  assign start = do_cp || do_cd || do_wb;

  assign err_set = fire && ((is_mut && busy) ||
                            (!busy && (cmd_op == OP_LOAD_HI) && !lo_seen) ||
                            (!busy && pg_op && !pg_ok) ||
                            bad_op);

  pcb_word_store #(.OFS_W(OFS_W), .PIDX_W(PIDX_W)) u_word (
    .clk(clk), .rst_n(rst_n), .ld_lo(do_lo), .ld_hi(do_hi), .commit(do_cp),
    .page(pidx), .ofs(ofs), .din(cmd_data), .rd_hi(cmd_op == OP_READ_HI),
    .lo_seen(lo_seen), .rd_data(word_rd)
  );

  pcb_byte_store #(.OFS_W(OFS_W), .PIDX_W(PIDX_W)) u_byte (
    .clk(clk), .rst_n(rst_n), .ld(do_lb), .commit(do_cd), .wr_byte(do_wb),
    .page(pidx), .ofs(ofs), .din(cmd_data), .rd_data(byte_rd)
  );

  pcb_busy_timer #(.TIME_W(TIME_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .wr_time(wr_time), .busy(busy)
  );

  always_comb begin
    if (!pg_ok)                       rd_sel = 8'h00;
    else if (cmd_op == OP_READ_DATA)  rd_sel = byte_rd;
    else                              rd_sel = word_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else if (fire && is_read) begin
      rsp_valid_q <= 1'b1;
      rsp_data_q  <= rd_sel;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       err_q <= 1'b0;
    else if (err_set) err_q <= 1'b1;
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;
  assign err       = err_q;
endmodule

// File: rtl/page_commit_buffer_chk.sv
module page_commit_buffer_chk #(
  parameter int OFS_W     = 6,
  parameter int PG_W      = 7,
  parameter int MEM_PAGES = 4,
  parameter int TIME_W    = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cmd_valid,
  input logic                  cmd_ready,
  input logic [3:0]            cmd_op,
  input logic [OFS_W+PG_W-1:0] cmd_addr,
  input logic [TIME_W-1:0]     wr_time,
  input logic                  rsp_valid,
  input logic                  rsp_ready,
  input logic [7:0]            rsp_data,
  input logic                  busy,
  input logic                  err
);
  localparam logic [PG_W-1:0] PG_LIMIT = PG_W'(MEM_PAGES);

  logic take, in_range, wr_op, starts;
  assign take     = cmd_valid && cmd_ready;
  assign in_range = cmd_addr[OFS_W+PG_W-1:OFS_W] < PG_LIMIT;
  assign wr_op    = (cmd_op == 4'd2) || (cmd_op == 4'd4) || (cmd_op == 4'd5);
  assign starts   = take && wr_op && !busy && in_range;

  p_stall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !cmd_ready);

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  p_read_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take && (cmd_op inside {4'd6, 4'd7, 4'd8}) |=> rsp_valid);

  p_busy_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    starts && (wr_time != '0) |=> busy);

  p_busy_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !starts |=> !busy);

  p_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take && busy && (cmd_op <= 4'd5) |=> err);

  p_bad_op_r10: assert property (@(posedge clk) disable iff (!rst_n)
    take && (cmd_op >= 4'd9) |=> err);

  p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
endmodule

bind page_commit_buffer page_commit_buffer_chk #(
  .OFS_W(OFS_W), .PG_W(PG_W), .MEM_PAGES(MEM_PAGES), .TIME_W(TIME_W)
) u_chk (.*);

// File: tb/page_commit_buffer_bench.sv
module page_commit_buffer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [3:0]  cmd_op = '0;
  logic [12:0] cmd_addr = '0;
  logic [7:0]  cmd_data = '0;
  logic [15:0] wr_time = 16'd2;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [7:0]  rsp_data;
  logic        busy, err;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  page_commit_buffer u_page_commit_buffer (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .wr_time(wr_time), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .busy(busy), .err(err)
  );

  function automatic logic [12:0] adr(int pg, int o);
    return {7'(pg), 6'(o)};
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cmd_valid = 1'b0;
    rsp_ready = 1'b1;
    wr_time = 16'd2;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic send(logic [3:0] op, logic [12:0] a, logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op = op;
    cmd_addr = a;
    cmd_data = d;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic rd(logic [3:0] op, int pg, int o, output logic [7:0] v);
    send(op, adr(pg, o), 8'h00);
    v = rsp_data;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    do_reset();
    chk("R11 busy after reset", busy, 0);
    chk("R11 err after reset", err, 0);
    chk("R11 rsp_valid after reset", rsp_valid, 0);
    chk("R11 cmd_ready after reset", cmd_ready, 1);
    send(4'd6, adr(0, 3), 8'h00);
    chk("R2 rsp_valid after read", rsp_valid, 1);
    chk("R2 erased program byte", rsp_data, 8'hFF);
    rd(4'd8, 3, 63, v);
    chk("R2 erased data byte", v, 8'hFF);
  endtask

  task automatic t_word();
    logic [7:0] v;
    do_reset();
    send(4'd0, adr(1, 5), 8'h3C);
    send(4'd1, adr(1, 5), 8'hA5);
    send(4'd2, adr(1, 0), 8'h00);
    wait_idle();
    rd(4'd6, 1, 5, v); chk("R3 low byte committed", v, 8'h3C);
    rd(4'd7, 1, 5, v); chk("R5 high byte committed", v, 8'hA5);
    rd(4'd6, 1, 6, v); chk("R5 unloaded word stays erased", v, 8'hFF);
    send(4'd0, adr(1, 5), 8'hF0);
    send(4'd1, adr(1, 5), 8'h0F);
    send(4'd2, adr(1, 0), 8'h00);
    wait_idle();
    rd(4'd6, 1, 5, v); chk("R5 AND programming low", v, 8'h30);
    rd(4'd7, 1, 5, v); chk("R5 AND programming high", v, 8'h05);
    chk("R3 no error on ordered loads", err, 0);
  endtask

  task automatic t_order();
    logic [7:0] v;
    do_reset();
    send(4'd1, adr(2, 7), 8'h11);
    chk("R4 high before low sets err", err, 1);
    send(4'd0, adr(2, 7), 8'h22);
    send(4'd2, adr(2, 0), 8'h00);
    wait_idle();
    rd(4'd7, 2, 7, v); chk("R4 early high byte dropped", v, 8'hFF);
    rd(4'd6, 2, 7, v); chk("R4 low byte kept", v, 8'h22);
    do_reset();
    send(4'd0, adr(0, 8), 8'h44);
    send(4'd2, adr(0, 0), 8'h00);
    wait_idle();
    chk("R5 no err before mark test", err, 0);
    send(4'd1, adr(0, 8), 8'h55);
    chk("R5 low marks cleared by commit", err, 1);
  endtask

  task automatic t_bytepage();
    logic [7:0] v;
    do_reset();
    send(4'd5, adr(3, 1), 8'h11); wait_idle();
    send(4'd5, adr(3, 2), 8'h22); wait_idle();
    send(4'd3, adr(3, 2), 8'h99);
    send(4'd3, adr(3, 3), 8'h33);
    send(4'd4, adr(3, 0), 8'h00); wait_idle();
    rd(4'd8, 3, 1, v); chk("R6 unloaded byte unchanged", v, 8'h11);
    rd(4'd8, 3, 2, v); chk("R6 loaded byte replaced", v, 8'h99);
    rd(4'd8, 3, 3, v); chk("R6 loaded byte on erased", v, 8'h33);
    rd(4'd8, 3, 4, v); chk("R6 other byte erased", v, 8'hFF);
    send(4'd5, adr(3, 2), 8'h5A); wait_idle();
    send(4'd4, adr(3, 0), 8'h00); wait_idle();
    rd(4'd8, 3, 2, v); chk("R6 marks cleared after commit", v, 8'h5A);
    rd(4'd6, 3, 2, v); chk("R6 program store untouched", v, 8'hFF);
  endtask

  task automatic t_erase();
    logic [7:0] v;
    do_reset();
    send(4'd5, adr(0, 10), 8'h0F); wait_idle();
    send(4'd5, adr(0, 10), 8'hF0); wait_idle();
    rd(4'd8, 0, 10, v);
    chk("R7 erase before write", v, 8'hF0);
  endtask

  task automatic t_busy();
    logic [7:0] v;
    do_reset();
    wr_time = 16'd5;
    send(4'd4, adr(0, 0), 8'h00);
    chk("R8 busy in cycle after commit", busy, 1);
    repeat (4) @(negedge clk);
    chk("R8 busy in last interval cycle", busy, 1);
    @(negedge clk);
    chk("R8 busy falls after wr_time", busy, 0);
    wr_time = 16'd0;
    send(4'd5, adr(0, 12), 8'h66);
    chk("R8 zero wr_time gives no busy", busy, 0);
    wr_time = 16'd6;
    send(4'd5, adr(0, 11), 8'h55);
    rd(4'd8, 0, 11, v);
    chk("R9 read served while busy", v, 8'h55);
    chk("R9 still busy during read", busy, 1);
    send(4'd5, adr(0, 11), 8'h12);
    chk("R9 write during busy sets err", err, 1);
    wait_idle();
    rd(4'd8, 0, 11, v);
    chk("R9 write during busy ignored", v, 8'h55);
  endtask

  task automatic t_range();
    logic [7:0] v;
    do_reset();
    rd(4'd8, 5, 0, v);
    chk("R2 out-of-range read value", v, 8'h00);
    chk("R2 out-of-range read no err", err, 0);
    send(4'd2, adr(5, 0), 8'h00);
    chk("R10 out-of-range commit err", err, 1);
    chk("R10 out-of-range commit no busy", busy, 0);
    do_reset();
    send(4'd12, adr(0, 0), 8'h00);
    chk("R10 unknown code err", err, 1);
  endtask

  task automatic t_backpressure();
    logic [7:0] v;
    do_reset();
    send(4'd5, adr(1, 9), 8'hC3); wait_idle();
    rsp_ready = 1'b0;
    send(4'd8, adr(1, 9), 8'h00);
    chk("R1 response held", rsp_valid, 1);
    chk("R1 cmd_ready low while held", cmd_ready, 0);
    @(negedge clk);
    chk("R1 held data stable", rsp_data, 8'hC3);
    chk("R1 still held", rsp_valid, 1);
    rsp_ready = 1'b1;
    #0;
    chk("R1 cmd_ready back on rsp_ready", cmd_ready, 1);
    @(negedge clk);
    chk("R1 response drained", rsp_valid, 0);
    rd(4'd8, 1, 9, v);
    chk("R1 later read still works", v, 8'hC3);
  endtask

  task automatic t_sticky();
    logic [7:0] v;
    do_reset();
    send(4'd13, adr(0, 0), 8'h00);
    send(4'd0, adr(0, 1), 8'h01);
    send(4'd2, adr(0, 0), 8'h00); wait_idle();
    rd(4'd6, 0, 1, v);
    chk("R11 err stays set", err, 1);
    chk("R11 commands work after err", v, 8'h01);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog (R1..all): actual=timeout expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_word();
    t_order();
    t_bytepage();
    t_erase();
    t_busy();
    t_range();
    t_backpressure();
    t_sticky();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule